// File: doc/BRIEF.md
# CAN Bit Timing Unit

This block divides the system clock into time quanta and walks each bit through three segments: a one-quantum sync segment, a first phase segment and a second phase segment. At the end of the first phase segment it raises a one-clock sample strobe and latches the received bit. The bit is taken either from one sample or from a majority of three samples taken one quantum apart. At the start of every sync segment it raises a transmit point, where a transmitter may drive the next bit.

The unit follows the bus edges. When the frame logic reports an idle bus, any falling edge on the receive line restarts the bit at the sync segment and restarts the quantum divider. This is a hard synchronization. Inside a frame, a falling edge that follows a recessive sampled bit triggers a resynchronization. A late edge in the first phase segment lengthens that segment. An early edge in the second phase segment shortens that segment or ends the bit at once. Each adjustment is capped at the configured jump width. Frame decoding and error counting belong to the surrounding controller.

Top module: `can_bit_timer`

## Requirements
- R1: One time quantum lasts 2*(brp_i+1) clocks.
- R2: With no edges, consecutive sample strobes are (tseg1_i+tseg2_i+3) quanta apart. The sync segment lasts 1 quantum, the first phase segment tseg1_i+1 quanta and the second phase segment tseg2_i+1 quanta.
- R3: sample_o is high for exactly one clock, the last clock of the first phase segment. After a bit start in cycle 0 it is high in cycle (tseg1_i+2)*Q-1, where Q is the quantum length in clocks.
- R4: Exactly one of in_sync_o, in_seg1_o and in_seg2_o is high in every cycle. tx_point_o is high only in the first clock of a sync segment.
- R5: When bus_idle_i is high, a falling edge on rx_i (rx_i low in a cycle after a high cycle) makes the next cycle the first clock of a sync segment, with the quantum divider restarted.
- R6: With bus_idle_i low and the last sampled bit recessive (1), a falling edge seen while quantum q (0-based) of the first phase segment is running lengthens that segment by min(q+1, sjw_i+1) quanta.
- R7: Under the same conditions, a falling edge seen in quantum q of the second phase segment is an early edge. If tseg2_i+1-q <= sjw_i+1, the next cycle starts a new bit. Otherwise the second phase segment is cut to tseg2_i-sjw_i quanta.
- R8: A falling edge during the sync segment, or any falling edge while the last sampled bit is dominant (0), leaves the bit timing unchanged.
- R9: With triple_i low, bit_o takes the value of rx_i from the sample cycle one clock later. bit_o changes at no other time.
- R10: With triple_i high, bit_o becomes the majority of rx_i in the sample cycle and rx_i in the last clock of each of the two preceding quanta.
- R11: After reset the unit is in the sync segment, with bit_o = 1 and sample_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Receive line, 1 = recessive |
| bus_idle_i | input | 1 | High while the bus is idle, which enables hard synchronization |
| brp_i | input | BRP_W | Quantum prescaler value |
| sjw_i | input | SJW_W | Jump width minus one |
| tseg1_i | input | TS1_W | First phase segment length minus one |
| tseg2_i | input | TS2_W | Second phase segment length minus one |
| triple_i | input | 1 | Selects three-sample majority |
| bit_o | output | 1 | Sampled bit value |
| sample_o | output | 1 | One-clock sample strobe |
| tx_point_o | output | 1 | First clock of the sync segment |
| in_sync_o | output | 1 | Sync segment active |
| in_seg1_o | output | 1 | First phase segment active |
| in_seg2_o | output | 1 | Second phase segment active |

## Verification
A wrong quantum count, segment length or jump clamp moves the sample strobe by whole quanta, so it shows at sample_o within one or two bit times after the disturbing edge. The bench predicts the exact cycle of the first two strobes after each hard synchronization. It does this across sweeps of prescaler, segment lengths, jump widths and edge positions. A wrong majority or a stale sample history shows in bit_o one clock after the second strobe. A broken segment encoding shows immediately as more than one segment indicator high.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;

  typedef enum logic [1:0] {
    SEG_SYNC = 2'd0,
    SEG_PH1  = 2'd1,
    SEG_PH2  = 2'd2
  } seg_e;

  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/can_bt_quantum.sv
module can_bt_quantum #(
  parameter int BRP_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BRP_W-1:0] brp_i,
  input  logic             restart_i,
  output logic             tq_o,
  output logic             first_o
);
  localparam int PW = BRP_W + 1;

  logic [PW-1:0] pcnt_q, pcnt_d;
  logic [PW-1:0] limit;

  // last clock index of a quantum: 2*(brp+1)-1
  assign limit   = {brp_i, 1'b1};
  assign tq_o    = (pcnt_q == limit);
  assign first_o = (pcnt_q == '0);

  always_comb begin
    pcnt_d = pcnt_q + PW'(1);
    if (restart_i || tq_o) pcnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end
endmodule

// File: rtl/can_bt_sampler.sv
module can_bt_sampler
  import can_bt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rx_i,
  input  logic tq_i,
  input  logic sample_i,
  input  logic triple_i,
  output logic bit_o
);
  logic [1:0] hist_q, hist_d;
  logic       bit_q, bit_d;

  always_comb begin
    hist_d = hist_q;
    bit_d  = bit_q;
    if (tq_i) hist_d = {hist_q[0], rx_i};
    if (sample_i) bit_d = triple_i ? vote3(rx_i, hist_q[0], hist_q[1]) : rx_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= 2'b11;
      bit_q  <= 1'b1;
    end else begin
      hist_q <= hist_d;
      bit_q  <= bit_d;
    end
  end

  assign bit_o = bit_q;
endmodule

// File: rtl/can_bt_segfsm.sv
module can_bt_segfsm
  import can_bt_pkg::*;
#(
  parameter int SJW_W = 2,
  parameter int TS1_W = 4,
  parameter int TS2_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tq_i,
  input  logic             fall_i,
  input  logic             bus_idle_i,
  input  logic             last_bit_i,
  input  logic [SJW_W-1:0] sjw_i,
  input  logic [TS1_W-1:0] tseg1_i,
  input  logic [TS2_W-1:0] tseg2_i,
  output seg_e             seg_o,
  output logic             restart_o,
  output logic             sample_o
);
  localparam int QW = TS1_W + 1;

  seg_e          seg_q, seg_d;
  logic [QW-1:0] q_q, q_d;
  logic [QW-1:0] ext_q, ext_d;
  logic          shrink_q, shrink_d;

  logic [QW-1:0] t1_w, t2_w, jw_w, qp1, ext_new, remain;
  logic [QW-1:0] ext_eff, ph1_last, ph2_last;
  logic          hard, rs_ok, late, early, early_restart, early_shrink, shrink_eff;

  always_comb begin
    t1_w   = QW'(tseg1_i);
    t2_w   = QW'(tseg2_i);
    jw_w   = QW'(sjw_i) + QW'(1);
    qp1    = q_q + QW'(1);
    ext_new = (qp1 < jw_w) ? qp1 : jw_w;
    remain = t2_w + QW'(1) - q_q;

    hard  = bus_idle_i & fall_i;
    rs_ok = ~bus_idle_i & fall_i & last_bit_i & (seg_q != SEG_SYNC);
    late  = rs_ok & (seg_q == SEG_PH1);
    early = rs_ok & (seg_q == SEG_PH2);
    early_restart = early & (remain <= jw_w);
    early_shrink  = early & ~early_restart;

    ext_eff    = late ? ext_new : ext_q;
    shrink_eff = shrink_q | early_shrink;
    ph1_last   = t1_w + ext_eff;
    ph2_last   = shrink_eff ? (t2_w - jw_w) : t2_w;

    restart_o = hard | early_restart;
    sample_o  = (seg_q == SEG_PH1) & tq_i & (q_q == ph1_last);
  end

  always_comb begin
    seg_d    = seg_q;
    q_d      = q_q;
    ext_d    = ext_q;
    shrink_d = shrink_q;
    if (restart_o) begin
      seg_d    = SEG_SYNC;
      q_d      = '0;
      ext_d    = '0;
      shrink_d = 1'b0;
    end else begin
      if (late)         ext_d    = ext_new;
      if (early_shrink) shrink_d = 1'b1;
      if (tq_i) begin
        unique case (seg_q)
          SEG_SYNC: begin
            seg_d = SEG_PH1;
            q_d   = '0;
          end
          SEG_PH1: begin
            if (q_q == ph1_last) begin
              seg_d = SEG_PH2;
              q_d   = '0;
            end else begin
              q_d = qp1;
            end
          end
          SEG_PH2: begin
            if (q_q == ph2_last) begin
              seg_d    = SEG_SYNC;
              q_d      = '0;
              ext_d    = '0;
              shrink_d = 1'b0;
            end else begin
              q_d = qp1;
            end
          end
          default: begin
            seg_d = SEG_SYNC;
            q_d   = '0;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q    <= SEG_SYNC;
      q_q      <= '0;
      ext_q    <= '0;
      shrink_q <= 1'b0;
    end else begin
      seg_q    <= seg_d;
      q_q      <= q_d;
      ext_q    <= ext_d;
      shrink_q <= shrink_d;
    end
  end

  assign seg_o = seg_q;
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer
  import can_bt_pkg::*;
#(
  parameter int BRP_W = 6,
  parameter int SJW_W = 2,
  parameter int TS1_W = 4,
  parameter int TS2_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_i,
  input  logic             bus_idle_i,
  input  logic [BRP_W-1:0] brp_i,
  input  logic [SJW_W-1:0] sjw_i,
  input  logic [TS1_W-1:0] tseg1_i,
  input  logic [TS2_W-1:0] tseg2_i,
  input  logic             triple_i,
  output logic             bit_o,
  output logic             sample_o,
  output logic             tx_point_o,
  output logic             in_sync_o,
  output logic             in_seg1_o,
  output logic             in_seg2_o
);
  logic [1:0] rst_pipe;
  logic       rst_core_n;
  logic       rx_prev_q, rx_prev_d;
  logic       fall, tq, first, restart, smp;
  seg_e       seg;

  // reset asserts at once, releases after two clocks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  assign rx_prev_d = rx_i;
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) rx_prev_q <= 1'b1;
    else             rx_prev_q <= rx_prev_d;
  end
  assign fall = rx_prev_q & ~rx_i;

  can_bt_quantum #(.BRP_W(BRP_W)) u_quantum (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .brp_i     (brp_i),
    .restart_i (restart),
    .tq_o      (tq),
    .first_o   (first)
  );

  can_bt_segfsm #(.SJW_W(SJW_W), .TS1_W(TS1_W), .TS2_W(TS2_W)) u_segfsm (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .tq_i       (tq),
    .fall_i     (fall),
    .bus_idle_i (bus_idle_i),
    .last_bit_i (bit_o),
    .sjw_i      (sjw_i),
    .tseg1_i    (tseg1_i),
    .tseg2_i    (tseg2_i),
    .seg_o      (seg),
    .restart_o  (restart),
    .sample_o   (smp)
  );

  can_bt_sampler u_sampler (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .rx_i     (rx_i),
    .tq_i     (tq),
    .sample_i (smp),
    .triple_i (triple_i),
    .bit_o    (bit_o)
  );

  assign sample_o   = smp;
  assign in_sync_o  = (seg == SEG_SYNC);
  assign in_seg1_o  = (seg == SEG_PH1);
  assign in_seg2_o  = (seg == SEG_PH2);
  assign tx_point_o = in_sync_o & first;
endmodule

// File: rtl/can_bit_timer_chk.sv
module can_bit_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic rx_i,
  input logic bus_idle_i,
  input logic triple_i,
  input logic bit_o,
  input logic sample_o,
  input logic tx_point_o,
  input logic in_sync_o,
  input logic in_seg1_o,
  input logic in_seg2_o
);
  logic rx_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_seen <= 1'b1;
    else        rx_seen <= rx_i;
  end

  // R4
  seg_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({in_sync_o, in_seg1_o, in_seg2_o}) == 1);

  // R4
  txpt_in_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_point_o |-> in_sync_o);

  // R3
  sample_in_seg1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_o |-> in_seg1_o);

  // R3
  sample_then_seg2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_o && !(bus_idle_i && rx_seen && !rx_i)) |=> (in_seg2_o && !sample_o));

  // R5
  hard_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_idle_i && rx_seen && !rx_i) |=> (in_sync_o && tx_point_o));

  // R9
  single_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_o && !triple_i) |=> (bit_o == $past(rx_i)));

  // R9
  bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_o |=> $stable(bit_o));
endmodule

bind can_bit_timer can_bit_timer_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rx_i       (rx_i),
  .bus_idle_i (bus_idle_i),
  .triple_i   (triple_i),
  .bit_o      (bit_o),
  .sample_o   (sample_o),
  .tx_point_o (tx_point_o),
  .in_sync_o  (in_sync_o),
  .in_seg1_o  (in_seg1_o),
  .in_seg2_o  (in_seg2_o)
);

// File: tb/can_bit_timer_tb.sv
`timescale 1ns/1ps
module can_bit_timer_tb;
  logic       clk;
  logic       rst_n;
  logic       rx;
  logic       idle;
  logic [5:0] brp;
  logic [1:0] sjw;
  logic [3:0] ts1;
  logic [2:0] ts2;
  logic       tri_s;
  logic       bit_v, smp, txp, s_sync, s_ph1, s_ph2;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit timed_out = 0;

  can_bit_timer u_dut (
    .clk(clk), .rst_n(rst_n), .rx_i(rx), .bus_idle_i(idle),
    .brp_i(brp), .sjw_i(sjw), .tseg1_i(ts1), .tseg2_i(ts2), .triple_i(tri_s),
    .bit_o(bit_v), .sample_o(smp), .tx_point_o(txp),
    .in_sync_o(s_sync), .in_seg1_o(s_ph1), .in_seg2_o(s_ph2)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input int act, input int exp, input string req);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // kind 0: rx low through bit 1, then 3-quantum pattern ending at the nominal 2nd sample
  // kind 1: rx high after bit start, falling at cpos
  // kind 2: rx low through 1st sample, high after, falling at cpos
  task automatic run_case(input int b, input int t1, input int t2, input int j,
                          input bit tr, input int kind, input int cpos, input logic [2:0] pat,
                          output int s1, output int s2, output int b2, output int tx0,
                          output int txn, output int txmid, output int oh_bad);
    int q, n, base, r, hits, s1n, s2n;
    q = 2 * (b + 1);
    n = (t1 + t2 + 3) * q;
    s1n = (t1 + 2) * q - 1;
    s2n = s1n + n;
    @(negedge clk);
    brp = 6'(b); ts1 = 4'(t1); ts2 = 3'(t2); sjw = 2'(j); tri_s = tr;
    idle = 1'b1; rx = 1'b1;
    repeat (4) @(negedge clk);
    rx = 1'b0;
    base = cyc + 1;
    s1 = -1; s2 = -1; b2 = -1; hits = 0; tx0 = -1; txn = -1; txmid = 0; oh_bad = 0;
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      r = cyc - base;
      if (r == 0) begin idle = 1'b0; tx0 = int'(txp); end
      if (r == n) txn = int'(txp);
      if (r > 0 && r < n && txp) txmid = 1;
      if (int'(s_sync) + int'(s_ph1) + int'(s_ph2) != 1) oh_bad = 1;
      if (hits == 2 && r == s2 + 1) begin
        b2 = int'(bit_v);
        break;
      end
      if (smp) begin
        if (hits == 0) s1 = r;
        else if (hits == 1) s2 = r;
        hits++;
      end
      case (kind)
        0: begin
          if (r <= s2n - 3 * q)  rx = 1'b0;
          else if (r <= s2n - 2 * q) rx = pat[2];
          else if (r <= s2n - q) rx = pat[1];
          else if (r <= s2n)     rx = pat[0];
          else                   rx = 1'b1;
        end
        1: rx = (r == 0) ? 1'b0 : (r < cpos) ? 1'b1 : 1'b0;
        default: rx = (r <= s1n) ? 1'b0 : (r < cpos) ? 1'b1 : 1'b0;
      endcase
    end
    @(negedge clk);
    rx = 1'b1; idle = 1'b1;
  endtask

  task automatic main_body();
    int s1, s2, b2, tx0, txn, txm, oh, q, n, s1n, e, exp2;
    rst_n = 1'b0; rx = 1'b1; idle = 1'b1;
    brp = 6'd0; sjw = 2'd0; ts1 = 4'd2; ts2 = 3'd1; tri_s = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R11 reset state
    check(int'(s_sync), 1, "R11 in_sync");
    check(int'(smp), 0, "R11 sample");
    check(int'(bit_v), 1, "R11 bit");

    // R1 R2 R3 R4 R5: nominal timing sweep
    for (int b = 0; b <= 2; b++)
      for (int t1 = 1; t1 <= 3; t1++)
        for (int t2 = 1; t2 <= 2; t2++) begin
          q = 2 * (b + 1);
          n = (t1 + t2 + 3) * q;
          run_case(b, t1, t2, 0, 1'b0, 0, 0, 3'b101, s1, s2, b2, tx0, txn, txm, oh);
          check(s1, (t1 + 2) * q - 1, "R3/R5 first sample after hard sync");
          check(s2 - s1, n, "R1/R2 bit period");
          check(b2, 1, "R9 single sample");
          check(tx0, 1, "R4 tx point at bit start");
          check(txn, 1, "R4 tx point at next bit");
          check(txm, 0, "R4 tx point inside bit");
          check(oh, 0, "R4 segment one-hot");
        end

    // R9 R10: majority vs single sample over all patterns
    for (int t = 0; t <= 1; t++)
      for (int p = 0; p < 8; p++) begin
        logic [2:0] pv;
        int expb;
        pv = 3'(p);
        expb = (t == 1) ? ((int'(pv[0]) + int'(pv[1]) + int'(pv[2])) >= 2 ? 1 : 0) : int'(pv[0]);
        run_case(0, 2, 1, 0, t[0], 0, 0, pv, s1, s2, b2, tx0, txn, txm, oh);
        check(s2 - s1, 12, "R8 dominant-bit edges ignored");
        check(b2, expb, (t == 1) ? "R10 majority" : "R9 single");
      end

    // R6 late edges: Q=4, tseg1=4, tseg2=2
    q = 4; n = (4 + 2 + 3) * q; s1n = 6 * q - 1;
    for (int j = 0; j <= 3; j++)
      for (int qi = 0; qi <= 4; qi++) begin
        e = (qi + 1 < j + 1) ? qi + 1 : j + 1;
        run_case(1, 4, 2, j, 1'b0, 1, n + q + qi * q + 1, 3'b000, s1, s2, b2, tx0, txn, txm, oh);
        check(s1, s1n, "R6 first sample");
        check(s2, s1n + n + e * q, "R6 late edge extension");
      end

    // R7 early edges in bit 1 second phase segment
    for (int j = 0; j <= 3; j++)
      for (int qi = 0; qi <= 2; qi++) begin
        int c;
        c = s1n + 1 + qi * q + 1;
        if (2 + 1 - qi <= j + 1) exp2 = c + 6 * q;
        else exp2 = s1n + 1 + (2 - j) * q + 6 * q - 1;
        run_case(1, 4, 2, j, 1'b0, 1, c, 3'b000, s1, s2, b2, tx0, txn, txm, oh);
        check(s2, exp2, "R7 early edge");
      end

    // R8 edge in sync segment, and edge after dominant sample
    for (int j = 0; j <= 3; j++) begin
      run_case(1, 4, 2, j, 1'b0, 1, n + 1, 3'b000, s1, s2, b2, tx0, txn, txm, oh);
      check(s2, s1n + n, "R8 sync-segment edge ignored");
      run_case(1, 4, 2, j, 1'b0, 2, n + q + 1, 3'b000, s1, s2, b2, tx0, txn, txm, oh);
      check(s2, s1n + n, "R8 edge after dominant bit ignored");
    end
  endtask

  initial begin
    fork
      main_body();
      begin
        #(200000 * 8);
        timed_out = 1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule